// File: doc/BRIEF.md
# Hot-Plug Slot Event and Interrupt Logic

This block keeps the event state for a bank of hot-plug slots and turns it into one level interrupt and one SERR request. Each slot has five sensor inputs: a two-bit presence code, the retention-latch sensor, the attention button, an isolated power fault and a connected power fault. A transition of interest on any of them sets a sticky event bit in that slot's register. Each event bit has its own interrupt mask. The latch-change and connected-fault events also have SERR masks. A controller register holds the global masks and two more sticky latches, one for command completion and one for arbiter errors.

Software reaches the block through a flat register port. Reads are combinational. A write takes effect at the clock edge where `reg_wr` is high. Event bits clear when a 1 is written to them, so writing back a value just read clears everything that was pending in it. An interrupt locator word shows which sources are pending. Bit 0 is the command-complete source and bit i+1 is slot i. Address 0 is the locator, address 1 is the controller register and address 2+i is slot i. Addresses past the last slot read as zero. The sensor inputs are taken as already synchronous to `clk`.

Top module: `hp_evt_irq`

## Requirements
- R1: Slot register bits 16..20 latch, in this order: a change of the presence code, a rising isolated fault, a rising button, any change of the latch sensor, and a rising connected fault. Falling fault and button edges set nothing. The sensor levels present when reset is released set no event.
- R2: Writing 1 to a slot event bit (16..20) or to controller bit 16 or 17 clears it. Writing 0 to any of these bits leaves it unchanged.
- R3: When a new event and a write-1 clear reach the same bit in the same cycle, the bit ends set.
- R4: Slot bits 24..28 are read/write interrupt masks for events 16..20, in the same order. A masked event stays latched but does not count as pending.
- R5: The locator (address 0) has bit 0 = command latch AND NOT command mask, and bit i+1 = slot i has any unmasked event. Bits for slots that do not exist read 0, and addresses beyond the last slot read 0.
- R6: `irq` is high exactly when the locator is non-zero and the global interrupt mask (controller bit 0) is clear. Setting that mask drops `irq` without losing any latched state.
- R7: `serr` is high when the global SERR mask (controller bit 1) is clear and one of these holds: a slot has latch-change event 19 with bit 29 clear, a slot has connected-fault event 20 with bit 30 clear, or arbiter latch bit 17 is set with arbiter mask bit 3 clear.
- R8: Controller register bits 3..0 are read/write masks that reset to 1. Bit 16 is set by `cmd_done` and bit 17 by `arb_err`. Bits 15..4 and 31..18 read 0 and ignore writes.
- R9: Slot status bits read the live sensors: bit 6 = 0 while either power fault is active, bit 7 = button level, bit 8 = 1 when the latch is open, bits 11..10 = presence code (3 means empty).
- R10: Slot bits 31, 15 and 21..23, and all status bits, read 0 or live values regardless of what is written to them.
- R11: After reset every slot has masks 24..30 set and no events, the locator is 0, and `irq` and `serr` are low.
- R12: Controller bit 2 masks the command-complete source from the locator and `irq` without clearing bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_prsnt | input | 2*NS | Presence code per slot, slot i at [2i+1:2i] |
| slot_latch_open | input | NS | Latch sensor per slot, 1 = open |
| slot_button | input | NS | Attention button level per slot |
| slot_iso_flt | input | NS | Isolated power fault per slot, 1 = fault |
| slot_con_flt | input | NS | Connected power fault per slot, 1 = fault |
| cmd_done | input | 1 | Command-completion pulse |
| arb_err | input | 1 | Arbiter error pulse |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| serr | output | 1 | SERR request |

## Verification
The bench targets four corner cases:
- A clear that lands in the same cycle as a new event. A design that gives the clear priority loses that event.
- A write of zeros or an all-ones write. A design that clears events on the wrong polarity, or stores reserved and status bits, returns the wrong read-back value.
- The global interrupt mask. A design that clears the latches along with the output has an empty locator when the mask is lifted again.
- Falling edges and reset-time sensor levels. A design that treats every level change as an event latches bits that should stay clear.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
  localparam int EV_N    = 5;
  localparam int B_PFN   = 6;
  localparam int B_BTN   = 7;
  localparam int B_LAT   = 8;
  localparam int B_PRS   = 10;
  localparam int B_EV    = 16;
  localparam int B_IMSK  = 24;
  localparam int B_SMSK  = 29;
  localparam int C_GIM   = 0;
  localparam int C_GSM   = 1;
  localparam int C_CIM   = 2;
  localparam int C_ASM   = 3;
  localparam int C_CMD   = 16;
  localparam int C_ARB   = 17;

  typedef enum int {
    EV_PRS = 0, EV_IPF = 1, EV_BTN = 2, EV_LAT = 3, EV_CPF = 4
  } ev_idx_e;

  function automatic logic pend_of(input logic [EV_N-1:0] ev,
                                   input logic [EV_N-1:0] im);
    return |(ev & ~im);
  endfunction

  function automatic logic serr_of(input logic [EV_N-1:0] ev,
                                   input logic [1:0] sm);
    return (ev[EV_LAT] & ~sm[0]) | (ev[EV_CPF] & ~sm[1]);
  endfunction
endpackage

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
  import hp_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            primed,
  input  logic [1:0]      prsnt,
  input  logic            latch_open,
  input  logic            button,
  input  logic            iso_flt,
  input  logic            con_flt,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     word,
  output logic            pend,
  output logic            serr_req,
  output logic [EV_N-1:0] ev_new,
  output logic [EV_N-1:0] ev_q
);
  logic [1:0]      prsnt_q;
  logic            lat_q, btn_q, ipf_q, cpf_q;
  logic [EV_N-1:0] im_q;
  logic [1:0]      sm_q;
  logic [EV_N-1:0] clr;

  always_comb begin
    ev_new = '0;
    if (primed) begin
      ev_new[EV_PRS] = (prsnt != prsnt_q);
      ev_new[EV_IPF] = iso_flt & ~ipf_q;
      ev_new[EV_BTN] = button & ~btn_q;
      ev_new[EV_LAT] = latch_open ^ lat_q;
      ev_new[EV_CPF] = con_flt & ~cpf_q;
    end
    clr = wr ? wdata[B_EV +: EV_N] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prsnt_q <= 2'b11;
      lat_q   <= 1'b0;
      btn_q   <= 1'b0;
      ipf_q   <= 1'b0;
      cpf_q   <= 1'b0;
      ev_q    <= '0;
      im_q    <= '1;
      sm_q    <= '1;
    end else begin
      prsnt_q <= prsnt;
      lat_q   <= latch_open;
      btn_q   <= button;
      ipf_q   <= iso_flt;
      cpf_q   <= con_flt;
      ev_q    <= (ev_q & ~clr) | ev_new;
      if (wr) begin
        im_q <= wdata[B_IMSK +: EV_N];
        sm_q <= wdata[B_SMSK +: 2];
      end
    end
  end

  always_comb begin
    word                 = '0;
    word[B_PFN]          = ~(iso_flt | con_flt);
    word[B_BTN]          = button;
    word[B_LAT]          = latch_open;
    word[B_PRS +: 2]     = prsnt;
    word[B_EV +: EV_N]   = ev_q;
    word[B_IMSK +: EV_N] = im_q;
    word[B_SMSK +: 2]    = sm_q;
  end

  assign pend     = pend_of(ev_q, im_q);
  assign serr_req = serr_of(ev_q, sm_q);
endmodule

// File: rtl/hp_ctl_unit.sv
module hp_ctl_unit
  import hp_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_done,
  input  logic        arb_err,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] word,
  output logic [3:0]  mask,
  output logic        cmd_q,
  output logic        arb_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= 4'hF;
      cmd_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      if (wr) mask <= wdata[3:0];
      cmd_q <= (cmd_q & ~(wr & wdata[C_CMD])) | cmd_done;
      arb_q <= (arb_q & ~(wr & wdata[C_ARB])) | arb_err;
    end
  end

  always_comb begin
    word        = '0;
    word[3:0]   = mask;
    word[C_CMD] = cmd_q;
    word[C_ARB] = arb_q;
  end
endmodule

// File: rtl/hp_evt_irq.sv
module hp_evt_irq
  import hp_evt_pkg::*;
#(
  parameter  int NS = 4,
  localparam int AW = $clog2(NS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NS-1:0] slot_prsnt,
  input  logic [NS-1:0]   slot_latch_open,
  input  logic [NS-1:0]   slot_button,
  input  logic [NS-1:0]   slot_iso_flt,
  input  logic [NS-1:0]   slot_con_flt,
  input  logic            cmd_done,
  input  logic            arb_err,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq,
  output logic            serr
);
  localparam int EVW = NS * EV_N;

  logic              primed;
  logic [31:0]       slot_word [NS];
  logic [NS-1:0]     slot_pend;
  logic [NS-1:0]     slot_serr;
  logic [EVW-1:0]    ev_new_all;
  logic [EVW-1:0]    ev_q_all;
  logic [31:0]       ctl_word;
  logic [3:0]        ctl_mask;
  logic              cmd_q, arb_q;
  logic [31:0]       loc;
  logic              gim, gsm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  hp_ctl_unit u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .arb_err(arb_err),
    .wr(reg_wr && reg_addr == AW'(1)), .wdata(reg_wdata),
    .word(ctl_word), .mask(ctl_mask), .cmd_q(cmd_q), .arb_q(arb_q)
  );

  for (genvar i = 0; i < NS; i++) begin : g_slot
    hp_slot_unit u_slot (
      .clk(clk), .rst_n(rst_n), .primed(primed),
      .prsnt(slot_prsnt[2*i +: 2]), .latch_open(slot_latch_open[i]),
      .button(slot_button[i]), .iso_flt(slot_iso_flt[i]),
      .con_flt(slot_con_flt[i]),
      .wr(reg_wr && reg_addr == AW'(i + 2)), .wdata(reg_wdata),
      .word(slot_word[i]), .pend(slot_pend[i]), .serr_req(slot_serr[i]),
      .ev_new(ev_new_all[i*EV_N +: EV_N]), .ev_q(ev_q_all[i*EV_N +: EV_N])
    );
  end

  assign gim = ctl_mask[C_GIM];
  assign gsm = ctl_mask[C_GSM];

  always_comb begin
    loc    = '0;
    loc[0] = cmd_q & ~ctl_mask[C_CIM];
    for (int i = 0; i < NS; i++) loc[i+1] = slot_pend[i];
  end

  assign irq  = ~gim & (loc != 32'd0);
  assign serr = ~gsm & ((arb_q & ~ctl_mask[C_ASM]) | (|slot_serr));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0))      reg_rdata = loc;
    else if (reg_addr == AW'(1)) reg_rdata = ctl_word;
    else begin
      for (int i = 0; i < NS; i++)
        if (reg_addr == AW'(i + 2)) reg_rdata = slot_word[i];
    end
  end
endmodule

// File: rtl/hp_evt_chk.sv
module hp_evt_chk #(
  parameter int NS  = 4,
  parameter int EVW = NS * 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic           serr,
  input logic [31:0]    loc,
  input logic           gim,
  input logic           gsm,
  input logic [EVW-1:0] ev_new_all,
  input logic [EVW-1:0] ev_q_all
);
  a_r1_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_new_all != '0) |=> ((ev_q_all & $past(ev_new_all)) == $past(ev_new_all)));

  a_r2_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q_all & ~$past(ev_q_all) & ~$past(ev_new_all)) == '0));

  a_r5_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (loc >> (NS + 1)) == 32'd0);

  a_r6_gmask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gim |-> !irq);

  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (loc != 32'd0));

  a_r6_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (!gim && loc != 32'd0) |-> irq);

  a_r7_gserr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    gsm |-> !serr);
endmodule

bind hp_evt_irq hp_evt_chk #(.NS(NS), .EVW(EVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .serr(serr), .loc(loc),
  .gim(gim), .gsm(gsm), .ev_new_all(ev_new_all), .ev_q_all(ev_q_all)
);

// File: tb/sim_hp_evt_irq.sv
module sim_hp_evt_irq;
  localparam int NS = 4;
  localparam int AW = $clog2(NS + 2);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2*NS-1:0] prsnt = '1;
  logic [NS-1:0]   lat = '0, btn = '0, ipf = '0, cpf = '0;
  logic            cmd_done = 1'b0, arb_err = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic            wr = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            irq, serr;
  int              n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  hp_evt_irq #(.NS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_prsnt(prsnt), .slot_latch_open(lat),
    .slot_button(btn), .slot_iso_flt(ipf), .slot_con_flt(cpf),
    .cmd_done(cmd_done), .arb_err(arb_err), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .serr(serr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rchk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk); addr = AW'(a); #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pins(input string tag, input logic ei, input logic es);
    #1; chk({tag, " irq"}, {31'd0, irq}, {31'd0, ei});
    chk({tag, " serr"}, {31'd0, serr}, {31'd0, es});
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    pins("R11 reset", 1'b0, 1'b0);
    rchk("R11 loc", 0, 32'h0);
    rchk("R8 ctl reset", 1, 32'h0000000F);
    rchk("R11 slot0", 2, 32'h7F000C40);
    rchk("R11 slot3", 5, 32'h7F000C40);
  endtask

  task automatic t_mask_event();
    cyc(); prsnt[3:2] = 2'b01; cyc();
    rchk("R4 masked event latched", 3, 32'h7F010440);
    pins("R4 masked", 1'b0, 1'b0);
    rchk("R5 masked loc", 0, 32'h0);
    wreg(1, 32'h0);
    wreg(3, 32'h0);
    pins("R4 unmasked", 1'b1, 1'b0);
    rchk("R5 loc slot1", 0, 32'h4);
    rchk("R2 zero write keeps", 3, 32'h00010440);
  endtask

  task automatic t_w1c();
    wreg(3, 32'h00010440);
    rchk("R2 writeback clears", 3, 32'h00000440);
    pins("R2 cleared", 1'b0, 1'b0);
    rchk("R2 loc", 0, 32'h0);
  endtask

  task automatic t_each_event();
    wreg(2, 32'h0);
    cyc(); ipf[0] = 1'b1; cyc();
    rchk("R1 iso fault bit17", 2, 32'h00020C00);
    rchk("R5 loc slot0", 0, 32'h2);
    cyc(); btn[0] = 1'b1; cyc();
    rchk("R1 button bit18", 2, 32'h00060C80);
    cyc(); lat[0] = 1'b1; cyc();
    rchk("R1 latch bit19", 2, 32'h000E0D80);
    cyc(); cpf[0] = 1'b1; cyc();
    rchk("R1 con fault bit20", 2, 32'h001E0D80);
    cyc(); prsnt[1:0] = 2'b00; cyc();
    rchk("R9 all events and status", 2, 32'h001F0180);
    wreg(2, 32'h001F0000);
    rchk("R2 clear all", 2, 32'h00000180);
    cyc(); ipf[0] = 1'b0; btn[0] = 1'b0; cpf[0] = 1'b0; cyc();
    rchk("R1 falling edges ignored", 2, 32'h00000140);
    cyc(); lat[0] = 1'b0; cyc();
    rchk("R1 latch close", 2, 32'h00080040);
    cyc(); prsnt[1:0] = 2'b11; cyc();
    rchk("R1 removal", 2, 32'h00090C40);
    wreg(2, 32'h00090000);
    rchk("R2 cleared slot0", 2, 32'h00000C40);
  endtask

  task automatic t_gmask();
    wreg(4, 32'h0);
    cyc(); btn[2] = 1'b1; cyc();
    pins("R6 pending", 1'b1, 1'b0);
    wreg(1, 32'h1);
    pins("R6 gmask", 1'b0, 1'b0);
    rchk("R6 loc kept", 0, 32'h8);
    rchk("R6 event kept", 4, 32'h00040CC0);
    wreg(1, 32'h0);
    pins("R6 unmask", 1'b1, 1'b0);
    wreg(4, 32'h00040000);
    cyc(); btn[2] = 1'b0; cyc();
    pins("R6 idle", 1'b0, 1'b0);
  endtask

  task automatic t_one_mask();
    wreg(4, 32'h04000000);
    cyc(); btn[2] = 1'b1; cyc();
    pins("R4 button masked", 1'b0, 1'b0);
    rchk("R4 word", 4, 32'h04040CC0);
    wreg(4, 32'h0);
    pins("R4 button unmasked", 1'b1, 1'b0);
    wreg(4, 32'h00040000);
    cyc(); btn[2] = 1'b0; cyc();
    pins("R4 idle", 1'b0, 1'b0);
  endtask

  task automatic t_serr();
    wreg(5, 32'h1F000000);
    cyc(); lat[3] = 1'b1; cyc();
    pins("R7 latch serr", 1'b0, 1'b1);
    wreg(5, 32'h3F000000);
    pins("R7 latch serr masked", 1'b0, 1'b0);
    wreg(5, 32'h1F000000);
    pins("R7 latch serr unmasked", 1'b0, 1'b1);
    wreg(1, 32'h2);
    pins("R7 global serr mask", 1'b0, 1'b0);
    wreg(1, 32'h0);
    wreg(5, 32'h1F080000);
    pins("R7 latch cleared", 1'b0, 1'b0);
    cyc(); cpf[3] = 1'b1; cyc();
    pins("R7 con fault serr", 1'b0, 1'b1);
    wreg(5, 32'h5F000000);
    pins("R7 con serr masked", 1'b0, 1'b0);
    wreg(5, 32'h5F100000);
    cyc(); cpf[3] = 1'b0; cyc();
  endtask

  task automatic t_cmd();
    cyc(); cmd_done = 1'b1; cyc(); cmd_done = 1'b0;
    rchk("R8 cmd latch", 1, 32'h00010000);
    rchk("R5 loc cmd", 0, 32'h1);
    pins("R12 cmd irq", 1'b1, 1'b0);
    wreg(1, 32'h4);
    rchk("R12 cmd masked loc", 0, 32'h0);
    pins("R12 cmd masked", 1'b0, 1'b0);
    rchk("R12 latch kept", 1, 32'h00010004);
    wreg(1, 32'h00010000);
    rchk("R2 cmd cleared", 1, 32'h0);
  endtask

  task automatic t_setwins();
    cyc(); cmd_done = 1'b1; cyc(); cmd_done = 1'b0;
    @(negedge clk); addr = AW'(1); wdata = 32'h00010000; wr = 1'b1; cmd_done = 1'b1;
    @(negedge clk); wr = 1'b0; cmd_done = 1'b0; wdata = '0;
    rchk("R3 cmd set wins", 1, 32'h00010000);
    @(negedge clk); addr = AW'(2); wdata = 32'h00020000; wr = 1'b1; ipf[0] = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
    rchk("R3 slot set wins", 2, 32'h00020C00);
    wreg(2, 32'h00020000);
    cyc(); ipf[0] = 1'b0; cyc();
    rchk("R3 slot cleared later", 2, 32'h00000C40);
    wreg(1, 32'h00010000);
  endtask

  task automatic t_arb();
    cyc(); arb_err = 1'b1; cyc(); arb_err = 1'b0;
    rchk("R8 arb latch", 1, 32'h00020000);
    pins("R7 arb serr", 1'b0, 1'b1);
    wreg(1, 32'h8);
    pins("R7 arb masked", 1'b0, 1'b0);
    rchk("R7 arb kept", 1, 32'h00020008);
    wreg(1, 32'h00020000);
    rchk("R2 arb cleared", 1, 32'h0);
  endtask

  task automatic t_reserved();
    wreg(3, 32'hFFFFFFFF);
    rchk("R10 slot reserved", 3, 32'h7F000440);
    wreg(1, 32'hFFFFFFFF);
    rchk("R8 ctl reserved", 1, 32'h0000000F);
    pins("R10 quiet", 1'b0, 1'b0);
    wreg(1, 32'h0);
  endtask

  task automatic t_absent();
    for (int s = 0; s < NS; s++) wreg(s + 2, 32'h0);
    cyc(); btn = '1; cyc();
    rchk("R5 all slots", 0, 32'h0000001E);
    rchk("R5 absent addr", 6, 32'h0);
    rchk("R5 absent addr7", 7, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset(); t_mask_event(); t_w1c(); t_each_event(); t_gmask();
        t_one_mask(); t_serr(); t_cmd(); t_setwins(); t_arb();
        t_reserved(); t_absent();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule